// File: doc/BRIEF.md
# Remote DMA Port Controller

This block is the host-driven remote DMA channel of an NE2000-style MAC register file. Software loads a 16-bit buffer address and a 16-bit byte count through byte-wide registers. It then writes a 3-bit opcode into the command register. From then on the host moves data through a single data port. Each access carries one byte or one 16-bit word, and the block steps the local buffer address and the remaining count on its own.

On a remote read, the block fetches the first word from the local buffer as soon as the command is accepted. Every later access starts the next fetch. While a fetch is still outstanding, the wait output is pulled low so that the host stretches its cycle. On a remote write, each accepted access is posted to the buffer at once. A following access waits until the buffer latency has elapsed.

The transfer finishes when the count reaches zero. At that point the block sets the top opcode bit and raises a completion flag in the interrupt status register. Software may abort a transfer at any time. An abort clears the count and leaves the current address where it stopped.

Top module: `rdma_port`

## Requirements
- R1: After reset the command register reads 0x21, the interrupt status register reads 0x80, the current address reads 0x0000, waitN is high and bufReq is low.
- R2: In page 0, writes to offsets 0x08 (low) and 0x09 (high) load the transfer address, and reads there return the current address. Writes to 0x0A (low) and 0x0B (high) load the byte count, and reads there return 0x00.
- R3: Command bits [7:6] select the page. With a nonzero page, every offset other than 0x00 reads 0x00 and ignores writes, while offset 0x00 stays fully accessible.
- R4: Command bits [5:3] hold the opcode: 001 starts a remote read, 010 starts a remote write, and any value with bit 5 set aborts. The codes 000 and 011, and a read or write opcode given while the count is zero, start nothing, so no bufReq follows.
- R5: Each data-port access steps the address by 2 when wordMode is high and by 1 when it is low. The count drops by the same step, but never below zero.
- R6: A remote read asserts bufReq (with bufWe low) on the cycle after the command and after each consumed access that leaves a nonzero count. A data-port read is held with waitN low until LATENCY cycles after that request. Word mode returns {buf[a+1], buf[a]}; byte mode returns {8'h00, buf[a]}.
- R7: A remote write issues bufReq with bufWe high, the port data and bufBe 2'b11 (word mode) or 2'b01 (byte mode) in the accepting cycle. A further write is held with waitN low for LATENCY cycles.
- R8: When the count reaches zero, command bit 5 becomes 1, interrupt status bit 6 becomes 1, and the channel returns to idle.
- R9: A command with bit 5 set clears the count, leaves the current address unchanged and does not set interrupt status bit 6.
- R10: Interrupt status bit 6 clears when 1 is written to it. Writes to bit 7 have no effect. Bit 7 is cleared by a command with bit 1 (start) set and set by a command with bit 0 (stop) set.
- R11: With no transfer active, data-port accesses keep waitN high, return 0x0000 on dataRdata and issue no bufReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe, one cycle |
| regAddr | input | 5 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| dataRd | input | 1 | Data-port read, held until waitN is high at an edge |
| dataWr | input | 1 | Data-port write, held until waitN is high at an edge |
| wordMode | input | 1 | 1: 16-bit access, 0: 8-bit access |
| dataWdata | input | 16 | Data-port write data |
| dataRdata | output | 16 | Data-port read data |
| waitN | output | 1 | Low while a data-port access must be stretched |
| bufReq | output | 1 | Local buffer access request |
| bufWe | output | 1 | Buffer request is a write |
| bufBe | output | 2 | Buffer byte enables |
| bufAddr | output | 16 | Buffer byte address |
| bufWdata | output | 16 | Buffer write data |
| bufRdata | input | 16 | Buffer read data, valid LATENCY cycles after a read request |

## Verification
Register writes and command effects are visible on the falling edge after the accepting rising edge, and register reads are combinational. The bench therefore samples each result one falling edge after its stimulus. A read request shows up on bufReq one cycle after the command. The wait count of a data-port read equals LATENCY when the read follows a consumed access directly, and LATENCY-1 when one cycle has been spent probing bufReq. The bench counts falling edges with waitN low and compares that count with these numbers. Write requests are sampled in the accepting cycle itself, and the written bytes are checked in the bench's memory once the transfer has completed.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;
  localparam logic [4:0] OFS_CMD   = 5'h00;
  localparam logic [4:0] OFS_ISR   = 5'h07;
  localparam logic [4:0] OFS_ADRLO = 5'h08;
  localparam logic [4:0] OFS_ADRHI = 5'h09;
  localparam logic [4:0] OFS_CNTLO = 5'h0A;
  localparam logic [4:0] OFS_CNTHI = 5'h0B;
  localparam logic [7:0] CMD_RESET = 8'h21;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READY, ST_WRITE} chanState_t;

  typedef struct packed {
    logic loadAddrLo;
    logic loadAddrHi;
    logic loadCntLo;
    logic loadCntHi;
    logic clearCnt;
    logic step;
    logic capture;
  } dpCtl_t;
endpackage

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [4:0]         regAddr,
  input  logic [7:0]         regWdata,
  input  logic [7:0]         cmdReg,
  input  logic               isrRst,
  input  logic               isrRdc,
  input  logic               wordMode,
  input  logic               pfReady,
  input  logic [15:0]        dataWdata,
  input  logic [15:0]        bufRdata,
  output logic [7:0]         regRdata,
  output logic [15:0]        dataRdata,
  output logic [ADDR_W-1:0]  bufAddr,
  output logic [15:0]        bufWdata,
  output logic [1:0]         bufBe,
  output logic               cntZero,
  output logic               lastStep
);
  logic [ADDR_W-1:0] curAddr;
  logic [15:0]       byteCnt;
  logic [15:0]       pfData;
  logic [15:0]       stepSize;
  logic              pageZero;

  assign stepSize = wordMode ? 16'd2 : 16'd1;
  assign cntZero  = (byteCnt == 16'd0);
  assign lastStep = (byteCnt <= stepSize);
  assign pageZero = (cmdReg[7:6] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      byteCnt <= '0;
      pfData  <= '0;
    end else begin
      if (ctl.loadAddrLo) curAddr[7:0]  <= regWdata;
      if (ctl.loadAddrHi) curAddr[15:8] <= regWdata;
      if (ctl.step)       curAddr <= curAddr + ADDR_W'(stepSize);
      if (ctl.clearCnt)       byteCnt <= '0;
      else if (ctl.loadCntLo) byteCnt[7:0]  <= regWdata;
      else if (ctl.loadCntHi) byteCnt[15:8] <= regWdata;
      else if (ctl.step)      byteCnt <= lastStep ? 16'd0 : byteCnt - stepSize;
      if (ctl.capture) pfData <= bufRdata;
    end
  end

  always_comb begin
    regRdata = 8'h00;
    if (regAddr == OFS_CMD) regRdata = cmdReg;
    else if (pageZero) begin
      case (regAddr)
        OFS_ISR:   regRdata = {isrRst, isrRdc, 6'b0};
        OFS_ADRLO: regRdata = curAddr[7:0];
        OFS_ADRHI: regRdata = curAddr[15:8];
        default:   regRdata = 8'h00;
      endcase
    end
  end

  assign dataRdata = !pfReady ? 16'h0000 : (wordMode ? pfData : {8'h00, pfData[7:0]});
  assign bufAddr   = curAddr;
  assign bufWdata  = dataWdata;
  assign bufBe     = wordMode ? 2'b11 : 2'b01;

  AST_STEP_DROPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.clearCnt && !ctl.loadCntLo && !ctl.loadCntHi && !cntZero) |=> (byteCnt < $past(byteCnt))); // R5
  AST_ABORT_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearCnt && !ctl.step) |=> $stable(curAddr)); // R9
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [4:0]  regAddr,
  input  logic [7:0]  regWdata,
  input  logic        dataRd,
  input  logic        dataWr,
  input  logic        cntZero,
  input  logic        lastStep,
  output dpCtl_t      ctl,
  output logic [7:0]  cmdReg,
  output logic        isrRst,
  output logic        isrRdc,
  output logic        pfReady,
  output logic        waitN,
  output logic        bufReq,
  output logic        bufWe
);
  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(LATENCY);

  chanState_t      st;
  logic [LAT_W-1:0] latCnt;
  logic            reqPend;
  logic            pageZero, cmdWr, abortCmd, rdCmd, wrCmd;
  logic            readHit, wrAccept, stepNow;
  logic [2:0]      newOp;

  assign pageZero = (cmdReg[7:6] == 2'b00);
  assign cmdWr    = regWr && (regAddr == OFS_CMD);
  assign newOp    = regWdata[5:3];
  assign abortCmd = cmdWr && newOp[2];
  assign rdCmd    = cmdWr && (newOp == 3'b001) && !cntZero;
  assign wrCmd    = cmdWr && (newOp == 3'b010) && !cntZero;
  assign readHit  = !cmdWr && (st == ST_READY) && dataRd;
  assign wrAccept = !cmdWr && (st == ST_WRITE) && dataWr && (latCnt == '0);
  assign stepNow  = readHit || wrAccept;

  always_comb begin
    ctl            = '0;
    ctl.loadAddrLo = regWr && pageZero && (regAddr == OFS_ADRLO);
    ctl.loadAddrHi = regWr && pageZero && (regAddr == OFS_ADRHI);
    ctl.loadCntLo  = regWr && pageZero && (regAddr == OFS_CNTLO);
    ctl.loadCntHi  = regWr && pageZero && (regAddr == OFS_CNTHI);
    ctl.clearCnt   = abortCmd;
    ctl.step       = stepNow;
    ctl.capture    = !cmdWr && (st == ST_FETCH) && (latCnt == LAT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      latCnt  <= '0;
      reqPend <= 1'b0;
      cmdReg  <= CMD_RESET;
      isrRst  <= 1'b1;
      isrRdc  <= 1'b0;
    end else begin
      reqPend <= 1'b0;
      if (cmdWr) begin
        cmdReg <= regWdata;
        if (regWdata[0])      isrRst <= 1'b1;
        else if (regWdata[1]) isrRst <= 1'b0;
        if (abortCmd) st <= ST_IDLE;
        else if (rdCmd) begin
          st      <= ST_FETCH;
          latCnt  <= LAT_LOAD;
          reqPend <= 1'b1;
        end else if (wrCmd) begin
          st     <= ST_WRITE;
          latCnt <= '0;
        end
      end else begin
        if (regWr && pageZero && (regAddr == OFS_ISR) && regWdata[6]) isrRdc <= 1'b0;
        case (st)
          ST_FETCH: begin
            latCnt <= latCnt - LAT_W'(1);
            if (latCnt == LAT_W'(1)) st <= ST_READY;
          end
          ST_READY: if (readHit) begin
            if (lastStep) begin
              st        <= ST_IDLE;
              cmdReg[5] <= 1'b1;
              isrRdc    <= 1'b1;
            end else begin
              st      <= ST_FETCH;
              latCnt  <= LAT_LOAD;
              reqPend <= 1'b1;
            end
          end
          ST_WRITE: begin
            if (latCnt != '0) latCnt <= latCnt - LAT_W'(1);
            if (wrAccept) begin
              if (lastStep) begin
                st        <= ST_IDLE;
                cmdReg[5] <= 1'b1;
                isrRdc    <= 1'b1;
              end else latCnt <= LAT_LOAD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pfReady = (st == ST_READY);
  assign waitN   = !((dataRd && (st == ST_FETCH)) ||
                     (dataWr && (st == ST_WRITE) && (latCnt != '0)));
  assign bufReq  = reqPend || wrAccept;
  assign bufWe   = wrAccept;

  AST_DONE_SETS_OPBIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isrRdc) |-> cmdReg[5]); // R8
  AST_ABORT_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |=> cntZero); // R9
  AST_RSTFLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFS_ISR) |=> (isrRst == $past(isrRst))); // R10
  AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE) |-> (waitN && !bufReq)); // R11
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [4:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        dataRd,
  input  logic        dataWr,
  input  logic        wordMode,
  input  logic [15:0] dataWdata,
  output logic [15:0] dataRdata,
  output logic        waitN,
  output logic        bufReq,
  output logic        bufWe,
  output logic [1:0]  bufBe,
  output logic [15:0] bufAddr,
  output logic [15:0] bufWdata,
  input  logic [15:0] bufRdata
);
  dpCtl_t     ctl;
  logic [7:0] cmdReg;
  logic       isrRst, isrRdc, pfReady, cntZero, lastStep;

  rdma_ctrl #(.LATENCY(LATENCY)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .dataRd(dataRd), .dataWr(dataWr), .cntZero(cntZero), .lastStep(lastStep),
    .ctl(ctl), .cmdReg(cmdReg), .isrRst(isrRst), .isrRdc(isrRdc), .pfReady(pfReady),
    .waitN(waitN), .bufReq(bufReq), .bufWe(bufWe)
  );

  rdma_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regAddr(regAddr), .regWdata(regWdata),
    .cmdReg(cmdReg), .isrRst(isrRst), .isrRdc(isrRdc), .wordMode(wordMode),
    .pfReady(pfReady), .dataWdata(dataWdata), .bufRdata(bufRdata),
    .regRdata(regRdata), .dataRdata(dataRdata), .bufAddr(bufAddr),
    .bufWdata(bufWdata), .bufBe(bufBe), .cntZero(cntZero), .lastStep(lastStep)
  );
endmodule

// File: tb/test_rdma_port.sv
module test_rdma_port;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic dataRd = 1'b0, dataWr = 1'b0, wordMode = 1'b1;
  logic [15:0] dataWdata = '0, dataRdata;
  logic waitN, bufReq, bufWe;
  logic [1:0] bufBe;
  logic [15:0] bufAddr, bufWdata, bufRdata;
  logic [7:0] mem [256];
  int nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_port #(.LATENCY(LAT)) i_rdma_port (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .dataRd(dataRd), .dataWr(dataWr), .wordMode(wordMode),
    .dataWdata(dataWdata), .dataRdata(dataRdata), .waitN(waitN), .bufReq(bufReq),
    .bufWe(bufWe), .bufBe(bufBe), .bufAddr(bufAddr), .bufWdata(bufWdata), .bufRdata(bufRdata)
  );

  assign bufRdata = {mem[bufAddr[7:0] + 8'd1], mem[bufAddr[7:0]]};
  always @(posedge clk) if (bufReq && bufWe) begin
    mem[bufAddr[7:0]] <= bufWdata[7:0];
    if (bufBe[1]) mem[bufAddr[7:0] + 8'd1] <= bufWdata[15:8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic portRead(input logic w, output logic [15:0] d, output int waits);
    @(negedge clk); dataRd = 1'b1; wordMode = w; waits = 0; #1;
    while (!waitN) begin waits++; @(negedge clk); #1; end
    d = dataRdata;
    @(posedge clk); #1 dataRd = 1'b0;
  endtask

  task automatic portWrite(input logic w, input logic [15:0] v, output int waits,
                           output logic [35:0] req);
    @(negedge clk); dataWr = 1'b1; wordMode = w; dataWdata = v; waits = 0; #1;
    while (!waitN) begin waits++; @(negedge clk); #1; end
    req = {bufReq, bufWe, bufBe, bufAddr, bufWdata};
    @(posedge clk); #1 dataWr = 1'b0;
  endtask

  task automatic probeIdle(input string tag);
    @(negedge clk); dataRd = 1'b1; #1;
    chk({tag, " waitN idle"}, waitN, 1);
    chk({tag, " data idle"}, dataRdata, 0);
    chk({tag, " no bufReq"}, bufReq, 0);
    @(posedge clk); #1 dataRd = 1'b0;
  endtask

  task automatic setupXfer(input logic [15:0] a, input logic [15:0] c);
    regWrite(5'h08, a[7:0]); regWrite(5'h09, a[15:8]);
    regWrite(5'h0A, c[7:0]); regWrite(5'h0B, c[15:8]);
  endtask

  task automatic testReset();
    logic [7:0] v;
    regRead(5'h00, v); chk("R1 cmd reset", v, 8'h21);
    regRead(5'h07, v); chk("R1 isr reset", v, 8'h80);
    regRead(5'h08, v); chk("R1 addr lo reset", v, 0);
    regRead(5'h09, v); chk("R1 addr hi reset", v, 0);
    chk("R1 waitN reset", waitN, 1);
    chk("R1 bufReq reset", bufReq, 0);
  endtask

  task automatic testRegMap();
    logic [7:0] v;
    setupXfer(16'h1234, 16'h0005);
    regRead(5'h08, v); chk("R2 addr lo", v, 8'h34);
    regRead(5'h09, v); chk("R2 addr hi", v, 8'h12);
    regRead(5'h0A, v); chk("R2 count lo reads 0", v, 0);
    regRead(5'h0B, v); chk("R2 count hi reads 0", v, 0);
  endtask

  task automatic testPage();
    logic [7:0] v;
    regWrite(5'h00, 8'h61);
    regWrite(5'h08, 8'hAA);
    regRead(5'h08, v); chk("R3 page1 offset reads 0", v, 0);
    regRead(5'h00, v); chk("R3 page1 cmd readable", v, 8'h61);
    regWrite(5'h00, 8'h21);
    regRead(5'h08, v); chk("R3 page1 write ignored", v, 8'h34);
  endtask

  task automatic testIllegal();
    logic [7:0] v;
    regWrite(5'h00, 8'h02);
    @(negedge clk); #1 chk("R4 op000 no bufReq", bufReq, 0);
    regRead(5'h07, v); chk("R10 start clears bit7", v, 8'h00);
    probeIdle("R11 after op000");
    regWrite(5'h00, 8'h1A);
    @(negedge clk); #1 chk("R4 op011 no bufReq", bufReq, 0);
    probeIdle("R11 after op011");
    regRead(5'h08, v); chk("R4 addr untouched", v, 8'h34);
  endtask

  task automatic testRead();
    logic [15:0] d; int w; logic [7:0] v;
    setupXfer(16'h0010, 16'd6);
    regWrite(5'h00, 8'h0A);
    @(negedge clk); #1;
    chk("R6 bufReq after cmd", bufReq, 1);
    chk("R6 bufWe low", bufWe, 0);
    chk("R6 bufAddr", bufAddr, 16'h0010);
    portRead(1'b1, d, w);
    chk("R6 first data", d, {mem[8'h11], mem[8'h10]});
    chk("R6 first waits", w, LAT - 1);
    portRead(1'b1, d, w);
    chk("R6 second data", d, {mem[8'h13], mem[8'h12]});
    chk("R6 second waits", w, LAT);
    regRead(5'h08, v); chk("R5 word step", v, 8'h14);
    portRead(1'b0, d, w);
    chk("R6 byte data", d, {8'h00, mem[8'h14]});
    regRead(5'h08, v); chk("R5 byte step", v, 8'h15);
    portRead(1'b1, d, w);
    chk("R6 last data", d, {mem[8'h16], mem[8'h15]});
    regRead(5'h08, v); chk("R5 last word step", v, 8'h17);
    regRead(5'h00, v); chk("R8 op bit5 set", v[5], 1);
    regRead(5'h07, v); chk("R8 isr bit6 set", v, 8'h40);
    probeIdle("R8 idle after done");
    regWrite(5'h07, 8'hC0);
    regRead(5'h07, v); chk("R10 w1c bit6, bit7 write ignored", v, 8'h00);
  endtask

  task automatic testWrite();
    int w; logic [35:0] r; logic [7:0] v;
    setupXfer(16'h0040, 16'd3);
    regWrite(5'h00, 8'h12);
    portWrite(1'b1, 16'hBEEF, w, r);
    chk("R7 first write waits", w, 0);
    chk("R7 word request", r, {1'b1, 1'b1, 2'b11, 16'h0040, 16'hBEEF});
    portWrite(1'b0, 16'h0077, w, r);
    chk("R7 second write waits", w, LAT);
    chk("R7 byte request", r, {1'b1, 1'b1, 2'b01, 16'h0042, 16'h0077});
    @(negedge clk);
    chk("R7 mem lo", mem[8'h40], 8'hEF);
    chk("R7 mem hi", mem[8'h41], 8'hBE);
    chk("R7 mem byte", mem[8'h42], 8'h77);
    chk("R7 byte enable kept neighbour", mem[8'h43], 8'h43 ^ 8'h5A);
    regRead(5'h07, v); chk("R8 write done isr", v, 8'h40);
    regRead(5'h08, v); chk("R5 write addr", v, 8'h43);
    regWrite(5'h07, 8'h40);
  endtask

  task automatic testAbort();
    logic [15:0] d; int w; logic [7:0] v;
    setupXfer(16'h0080, 16'd10);
    regWrite(5'h00, 8'h0A);
    portRead(1'b1, d, w);
    chk("R6 pre-abort data", d, {mem[8'h81], mem[8'h80]});
    regWrite(5'h00, 8'h22);
    regRead(5'h08, v); chk("R9 addr not rewound", v, 8'h82);
    regRead(5'h07, v); chk("R9 no completion flag", v, 8'h00);
    probeIdle("R9 idle after abort");
    regWrite(5'h00, 8'h0A);
    @(negedge clk); #1 chk("R9 count cleared, no bufReq", bufReq, 0);
    regWrite(5'h00, 8'h21);
    regRead(5'h07, v); chk("R10 stop sets bit7", v, 8'h80);
    regWrite(5'h07, 8'h80);
    regRead(5'h07, v); chk("R10 bit7 write no effect", v, 8'h80);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegMap();
    testPage();
    testIllegal();
    testRead();
    testWrite();
    testAbort();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule